// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block sits between an 8-bit parallel host bus and a pair of 12-bit converters. Each channel needs a 12-bit code, and the host writes it in two parts: a full byte for the lower eight bits and a nibble for the upper four. The host then moves the code into an output register that drives the converter. The host strobes are active-low: chip select, write, update and clear. Two address lines pick the channel and the part. The strobes are brought into the system clock through a synchroniser, and each register commits when the synchronised write strobe returns high.

Because the input registers and the output registers are separate, new codes can be staged for both channels while the converters keep their old values. A single update strobe then moves both codes at once. If select and update are asserted together, writes pass straight through to the outputs. The clear input is an asynchronous active-low reset that zeroes every register.

Top module: `dual_dac_regif`

## Requirements
- R1: A write with address bit 0 low loads data bits 7..0 into the low byte input register of the addressed channel.
- R2: A write with address bit 0 high loads data bits 3..0 into the high nibble input register of the addressed channel. Data bits 7..4 affect no register.
- R3: Address bit 1 selects the channel: 0 for channel A, 1 for channel B. Input registers load only when chip select and write are both low, and the other channel's registers keep their values.
- R4: A write with update high changes only input registers, and both output codes stay unchanged.
- R5: A write pulse with update low copies both channels' input registers into their output codes, and both outputs change on the same clock edge.
- R6: With chip select, update and write all low, the written value reaches the selected channel's output together with its input register, and the other channel's output follows its own input registers.
- R7: Taking clear low zeroes every input register and both output codes at once, without waiting for a clock edge.
- R8: A write pulse with chip select and update both high changes no register.
- R9: A committed write shows at the outputs on the third rising clock edge after the write strobe rises, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low clear of all registers |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe, commits on its rising edge |
| upd_ni | input | 1 | Active-low transfer of input registers to outputs |
| addr_i | input | 2 | Bit 1 selects the channel, bit 0 selects the low byte or the high nibble |
| data_i | input | 8 | Host data bus |
| code_a_o | output | 12 | Converter code of channel A |
| code_b_o | output | 12 | Converter code of channel B |

## Verification
The bench builds the block with its defaults: a 12-bit code, an 8-bit bus, two channels and two synchroniser stages. With these defaults the commit latency of R9 is a fixed three edges, so the bench's behavioural model can track every register on every clock and check the exact edge on which both outputs move. Using the full-width bus lets the bench drive nonzero upper data bits on nibble writes, which makes R2 observable. Clear is applied between the two halves of a channel load, so the bench can show that staged input values are gone as well as the outputs.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int CODE_W = 12;
  localparam int BUS_W  = 8;
  localparam int LO_W   = BUS_W;
  localparam int HI_W   = CODE_W - LO_W;
  localparam int NUM_CH = 2;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = CH_W + 1;

  typedef struct packed {
    logic              cs_n;
    logic              upd_n;
    logic              wr_n;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  data;
  } bus_t;

  localparam bus_t BUS_IDLE = '{cs_n: 1'b1, upd_n: 1'b1, wr_n: 1'b1,
                                addr: '0, data: '0};
endpackage

// File: rtl/dac_bus_sync.sv
module dac_bus_sync #(
  parameter int           W       = 8,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_commit_ctrl.sv
module dac_commit_ctrl
  import dac_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_t              bus_i,
  output logic              upd_o,
  output logic [NUM_CH-1:0] ld_lo_o,
  output logic [NUM_CH-1:0] ld_hi_o,
  output logic [LO_W-1:0]   lo_data_o,
  output logic [HI_W-1:0]   hi_data_o
);
  logic              wr_prev_q;
  logic              cs_n_q;
  logic              upd_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic              commit;

  // hold the bus fields seen while the strobe is low; they are used at its release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b1;
      cs_n_q    <= 1'b1;
      upd_n_q   <= 1'b1;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      wr_prev_q <= bus_i.wr_n;
      if (!bus_i.wr_n) begin
        cs_n_q  <= bus_i.cs_n;
        upd_n_q <= bus_i.upd_n;
        addr_q  <= bus_i.addr;
        data_q  <= bus_i.data;
      end
    end
  end

  assign commit    = bus_i.wr_n & ~wr_prev_q;
  assign upd_o     = commit & ~upd_n_q;
  assign lo_data_o = data_q[LO_W-1:0];
  assign hi_data_o = data_q[HI_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic sel;
    assign sel        = commit & ~cs_n_q & (addr_q[ADDR_W-1:1] == CH_W'(c));
    assign ld_lo_o[c] = sel & ~addr_q[0];
    assign ld_hi_o[c] = sel &  addr_q[0];
  end

  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_lo_o, ld_hi_o})); // R3
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              upd_i,
  input  logic [LO_W-1:0]   lo_data_i,
  input  logic [HI_W-1:0]   hi_data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [LO_W-1:0]   lo_q, lo_nx;
  logic [HI_W-1:0]   hi_q, hi_nx;
  logic [CODE_W-1:0] dac_q;

  assign lo_nx = ld_lo_i ? lo_data_i : lo_q;
  assign hi_nx = ld_hi_i ? hi_data_i : hi_q;

  // output takes the post-write input value, which also covers pass-through
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      dac_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
      if (upd_i) dac_q <= {hi_nx, lo_nx};
    end
  end

  assign code_o = dac_q;

  AST_INPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_lo_i || ld_hi_i) |=> $stable({hi_q, lo_q})); // R3
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              upd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);
  localparam int BUS_BITS = $bits(bus_t);

  bus_t                bus_raw;
  logic [BUS_BITS-1:0] bus_sync;
  logic                upd;
  logic [NUM_CH-1:0]   ld_lo, ld_hi;
  logic [LO_W-1:0]     lo_data;
  logic [HI_W-1:0]     hi_data;
  logic [CODE_W-1:0]   code [NUM_CH];

  assign bus_raw = '{cs_n: cs_ni, upd_n: upd_ni, wr_n: wr_ni, addr: addr_i, data: data_i};

  dac_bus_sync #(
    .W      (BUS_BITS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_sync)
  );

  dac_commit_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    (bus_t'(bus_sync)),
    .upd_o    (upd),
    .ld_lo_o  (ld_lo),
    .ld_hi_o  (ld_hi),
    .lo_data_o(lo_data),
    .hi_data_o(hi_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel #(.LO_W(LO_W), .HI_W(HI_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_lo_i  (ld_lo[c]),
      .ld_hi_i  (ld_hi[c]),
      .upd_i    (upd),
      .lo_data_i(lo_data),
      .hi_data_i(hi_data),
      .code_o   (code[c])
    );
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable({code_a_o, code_b_o})); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (code_a_o == '0 && code_b_o == '0)); // R7
endmodule

// File: tb/dual_dac_regif_test.sv
module dual_dac_regif_test;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        cs_n = 1'b1, upd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [11:0] code_a, code_b;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_dac_regif uut (
    .clk_i(clk), .rst_ni(clr_n), .cs_ni(cs_n), .wr_ni(wr_n), .upd_ni(upd_n),
    .addr_i(addr), .data_i(data), .code_a_o(code_a), .code_b_o(code_b)
  );

  // reference model: bit 12 wr, 11 cs, 10 upd, 9 channel, 8 nibble select, 7..0 data
  localparam logic [12:0] IDLE = 13'h1C00;
  logic [12:0] p1 = IDLE, p2 = IDLE, p3 = IDLE;
  logic [7:0]  m_lo [2];
  logic [3:0]  m_hi [2];
  logic [11:0] m_dac [2];

  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      p1 = IDLE; p2 = IDLE; p3 = IDLE;
      for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_dac[c] = '0; end
    end else begin
      if (p2[12] && !p3[12]) begin
        if (!p3[11]) begin
          if (!p3[8]) m_lo[p3[9]] = p3[7:0];
          else        m_hi[p3[9]] = p3[3:0];
        end
        if (!p3[10])
          for (int c = 0; c < 2; c++) m_dac[c] = {m_hi[c], m_lo[c]};
      end
      p3 = p2; p2 = p1; p1 = {wr_n, cs_n, upd_n, addr, data};
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model covers the R9 commit edge
  always @(negedge clk) if (clr_n) begin
    chk("R9 model A", code_a, m_dac[0]);
    chk("R9 model B", code_b, m_dac[1]);
  end

  task automatic bus_wr(input logic c, input logic u, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = c; upd_n = u; addr = a; data = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; upd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset A", code_a, 12'h000);
    chk("R7 reset B", code_b, 12'h000);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);

    // stage both channels, nibble write carries junk in bits 7..4
    bus_wr(1'b0, 1'b1, 2'd0, 8'h34);
    bus_wr(1'b0, 1'b1, 2'd1, 8'hF2);
    bus_wr(1'b0, 1'b1, 2'd2, 8'hCD);
    bus_wr(1'b0, 1'b1, 2'd3, 8'hBA);
    chk("R4 staged A", code_a, 12'h000);
    chk("R4 staged B", code_b, 12'h000);

    bus_wr(1'b1, 1'b1, 2'd1, 8'h55);
    chk("R8 idle strobe A", code_a, 12'h000);
    chk("R8 idle strobe B", code_b, 12'h000);

    // update with exact edge check
    @(negedge clk); upd_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 early A", code_a, 12'h000);
    chk("R9 early B", code_b, 12'h000);
    @(posedge clk); @(negedge clk);
    chk("R5 R1 R2 update A", code_a, 12'h234);
    chk("R5 R3 update B", code_b, 12'hACD);
    upd_n = 1'b1;
    repeat (3) @(negedge clk);

    bus_wr(1'b0, 1'b1, 2'd0, 8'h99);
    bus_wr(1'b0, 1'b1, 2'd3, 8'h05);
    chk("R4 input only A", code_a, 12'h234);
    chk("R4 R3 input only B", code_b, 12'hACD);

    bus_wr(1'b0, 1'b0, 2'd1, 8'h0E);
    chk("R6 transparent A", code_a, 12'hE99);
    chk("R6 follow B", code_b, 12'h5CD);

    // clear between the two halves of a load
    bus_wr(1'b0, 1'b1, 2'd0, 8'h11);
    @(negedge clk); clr_n = 1'b0;
    #1;
    chk("R7 async A", code_a, 12'h000);
    chk("R7 async B", code_b, 12'h000);
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    bus_wr(1'b0, 1'b1, 2'd1, 8'h07);
    bus_wr(1'b1, 1'b0, 2'd0, 8'h00);
    chk("R7 cleared A", code_a, 12'h700);
    chk("R7 cleared B", code_b, 12'h000);

    bus_wr(1'b0, 1'b0, 2'd2, 8'h3C);
    chk("R6 transparent B", code_b, 12'h03C);
    chk("R6 follow A", code_a, 12'h700);

    done = 1;
    summary();
    $finish;
  end
endmodule